// File: doc/BRIEF.md
# Taint Tag Cache

This block keeps the security tag bits of a decoupled taint-tracking coprocessor close at hand. Every data byte of main memory owns one tag bit, so eight data bytes share one tag byte. The coprocessor hands the block the address of an eight-byte data chunk and either reads the tag byte of that chunk or replaces it. The tag byte is stored in a two-way set-associative, write-back cache of tag lines. Tag reads and writes are handled by this cache only, never by the main core's caches.

A hit is answered one cycle after the request. A miss raises `busy`, which stalls the coprocessor. The block then uses a word-wide request/response port, shared with the main core's own misses, to write back a dirty victim line and to fill the missing line. When the fill is complete it finishes the held access and gives its response. Each transfer on that port takes the bus away from the main core, so the number of beats per miss is part of the contract.

Named states: `ST_IDLE` (lookup), `ST_WBACK` (victim write-back beats), `ST_FREQ` (issue one fill read), `ST_FWAIT` (wait for that read's word), `ST_DONE` (finish the held access). The transitions are:
- idle to idle on a hit;
- idle to write-back on a miss with a dirty victim;
- idle to fill-request on a miss with a clean victim;
- write-back to fill-request after the last beat is accepted;
- fill-request to fill-wait when the read is accepted;
- fill-wait to fill-request after a word that is not the last;
- fill-wait to done after the last word;
- done to idle.

Top module: `taint_tag_cache`

## Requirements
- R1: After reset `busy`, `rsp_valid` and `mem_req_valid` are low, and every line is invalid.
- R2: A read that hits gives `rsp_valid` with the stored tag byte in the cycle after acceptance, with no memory traffic.
- R3: A write that hits stores `req_wtag`, echoes it on `rsp_rtag` the next cycle, and marks the line dirty. Later reads return it.
- R4: `req_addr` is the data address shifted right by three. Bit k of a tag byte covers data byte k of its chunk. A line holds LINE_BYTES tag bytes. Memory word address = {line, beat, 2'b00}, and tag byte 4·beat+j travels on bits [8j+7:8j].
- R5: A miss raises `busy` from the next cycle until the cycle its response appears. Requests presented while `busy` is high are ignored. When `busy` falls, `rsp_valid` carries the held access's result.
- R6: A fill issues LINE_BYTES/4 read beats in ascending word order, starting at the line base, with at most one read outstanding.
- R7: A dirty victim is written out as LINE_BYTES/4 ascending write beats, all accepted before the first fill read.
- R8: The victim is way 0 if that way is invalid, else way 1 if that way is invalid, else the least recently used way of the set. One LRU bit per set is updated on every completed access.
- R9: A line that was only filled and read is replaced with no write-back beats.
- R10: A memory request that is not yet accepted keeps its valid, direction, address and data unchanged until `mem_req_ready`.
- R11: The set index is the line address modulo CACHE_BYTES/(2·LINE_BYTES). Lines of different sets never evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Tag access request, taken when `busy` is low |
| req_write | input | 1 | 1 = replace tag byte, 0 = read it |
| req_addr | input | CHUNK_W | Data address bits above the byte-in-chunk field |
| req_wtag | input | 8 | Tag byte to store on a write |
| busy | output | 1 | Miss in service; requests ignored |
| rsp_valid | output | 1 | Access complete this cycle |
| rsp_rtag | output | 8 | Tag byte read, or the byte written |
| mem_req_valid | output | 1 | Memory beat request |
| mem_req_write | output | 1 | 1 = write-back beat, 0 = fill read |
| mem_req_addr | output | CHUNK_W | Tag-space byte address, word aligned |
| mem_req_wdata | output | 32 | Write-back word |
| mem_req_ready | input | 1 | Shared bus accepts the request |
| mem_rsp_valid | input | 1 | Fill word returned |
| mem_rsp_rdata | input | 32 | Fill word |

## Verification
Two events can fall on the same edge: the cycle in which a held miss completes (`ST_DONE`) and a fresh request from the coprocessor. The bench provokes this by presenting a tag write while `busy` is high. It then reads that chunk back and expects the value from before the ignored write. The other overlap is the write-back and fill of one miss competing on the shared port under random ready stalls and response delays. The bus model counts beats per miss and flags any write beat after a fill read of the same miss, any out-of-order or overlapping beat, and any request that changes while stalled. Every read of a full sweep and of a set-thrashing random stream is compared against a flat reference array of tag bytes.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WBACK = 3'd1,
        ST_FREQ  = 3'd2,
        ST_FWAIT = 3'd3,
        ST_DONE  = 3'd4
    } ttc_state_e;
endpackage

// File: rtl/ttc_dir.sv
module ttc_dir #(
    parameter int SETS   = 16,
    parameter int SET_W  = 4,
    parameter int LINE_W = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [LINE_W-1:0] lk_line,
    input  logic              op_way,
    input  logic              touch_en,
    input  logic              inst_en,
    input  logic              dirty_en,
    output logic [1:0]        hit,
    output logic              hit_way,
    output logic              vic_way,
    output logic              vic_dirty,
    output logic [LINE_W-1:0] vic_line
);
    logic [1:0]        val_q [SETS];
    logic [1:0]        dty_q [SETS];
    logic [SETS-1:0]   lru_q;
    logic [LINE_W-1:0] tag_q [2][SETS];

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign hit[w] = val_q[lk_set][w] && (tag_q[w][lk_set] == lk_line);
    end

    assign hit_way   = hit[1];
    assign vic_way   = !val_q[lk_set][0] ? 1'b0 :
                       !val_q[lk_set][1] ? 1'b1 : lru_q[lk_set];
    assign vic_dirty = val_q[lk_set][vic_way] && dty_q[lk_set][vic_way];
    assign vic_line  = tag_q[vic_way][lk_set];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                val_q[s] <= '0;
                dty_q[s] <= '0;
            end
            lru_q <= '0;
        end else begin
            if (touch_en) lru_q[lk_set] <= ~op_way;
            if (inst_en) begin
                val_q[lk_set][op_way] <= 1'b1;
                dty_q[lk_set][op_way] <= 1'b0;
            end
            if (dirty_en) dty_q[lk_set][op_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (inst_en) tag_q[op_way][lk_set] <= lk_line;
    end

    // R8: a line address may live in at most one way
    p_hit_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R9: a freshly installed line starts clean
    p_inst_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inst_en |=> !dty_q[$past(lk_set)][$past(op_way)]);
endmodule

// File: rtl/ttc_store.sv
module ttc_store #(
    parameter int SETS       = 16,
    parameter int SET_W      = 4,
    parameter int LINE_BYTES = 16,
    parameter int BYTE_W     = 4,
    parameter int BEAT_W     = 2
) (
    input  logic              clk,
    input  logic [SET_W-1:0]  set_idx,
    input  logic              way,
    input  logic [BYTE_W-1:0] byte_idx,
    input  logic [BEAT_W-1:0] beat_idx,
    input  logic              we_word,
    input  logic [31:0]       wr_word,
    input  logic              we_byte,
    input  logic [7:0]        wr_tag,
    output logic [7:0]        rd_tag,
    output logic [31:0]       rd_word
);
    localparam int LINE_BITS = LINE_BYTES * 8;

    logic [LINE_BITS-1:0] rd_line [2];

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [LINE_BITS-1:0] arr [SETS];
        always_ff @(posedge clk) begin
            if (we_word && (way == 1'(w)))
                arr[set_idx][int'(beat_idx)*32 +: 32] <= wr_word;
            else if (we_byte && (way == 1'(w)))
                arr[set_idx][int'(byte_idx)*8 +: 8] <= wr_tag;
        end
        assign rd_line[w] = arr[set_idx];
    end

    assign rd_tag  = rd_line[way][int'(byte_idx)*8 +: 8];
    assign rd_word = rd_line[way][int'(beat_idx)*32 +: 32];
endmodule

// File: rtl/ttc_ctrl.sv
module ttc_ctrl
    import ttc_pkg::*;
#(
    parameter int CHUNK_W = 29,
    parameter int SETS    = 16,
    parameter int SET_W   = 4,
    parameter int BYTE_W  = 4,
    parameter int BEAT_W  = 2,
    parameter int LINE_W  = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [CHUNK_W-1:0] req_addr,
    input  logic [7:0]         req_wtag,
    output logic               busy,
    output logic               rsp_valid,
    output logic [7:0]         rsp_rtag,
    output logic               mem_req_valid,
    output logic               mem_req_write,
    output logic [CHUNK_W-1:0] mem_req_addr,
    output logic [31:0]        mem_req_wdata,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    output logic [SET_W-1:0]   lk_set,
    output logic [LINE_W-1:0]  lk_line,
    input  logic [1:0]         hit,
    input  logic               hit_way,
    input  logic               vic_way,
    input  logic               vic_dirty,
    input  logic [LINE_W-1:0]  vic_line,
    output logic               op_way,
    output logic               touch_en,
    output logic               inst_en,
    output logic               dirty_en,
    output logic [BYTE_W-1:0]  st_byte,
    output logic [BEAT_W-1:0]  st_beat,
    output logic               we_word,
    output logic               we_byte,
    output logic [7:0]         wr_tag,
    input  logic [7:0]         st_rd_tag,
    input  logic [31:0]        st_rd_word
);
    ttc_state_e         state_q, state_d;
    logic [CHUNK_W-1:0] pend_addr_q;
    logic               pend_write_q;
    logic [7:0]         pend_wtag_q;
    logic               way_q;
    logic [LINE_W-1:0]  vline_q;
    logic [BEAT_W-1:0]  beat_q;
    logic               rsp_valid_q;
    logic [7:0]         rsp_tag_q;
    logic               capture, beat_inc, beat_clr, do_rsp;
    logic               idle, op_write;
    logic [CHUNK_W-1:0] look_addr;

    assign idle      = (state_q == ST_IDLE);
    assign look_addr = idle ? req_addr : pend_addr_q;
    assign lk_line   = look_addr[CHUNK_W-1:BYTE_W];
    assign lk_set    = (SETS > 1) ? lk_line[SET_W-1:0] : '0;
    assign st_byte   = look_addr[BYTE_W-1:0];
    assign st_beat   = beat_q;
    assign op_way    = idle ? hit_way : way_q;
    assign op_write  = idle ? req_write : pend_write_q;
    assign wr_tag    = idle ? req_wtag : pend_wtag_q;
    assign busy      = !idle;
    assign rsp_valid = rsp_valid_q;
    assign rsp_rtag  = rsp_tag_q;
    assign mem_req_wdata = st_rd_word;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d       = state_q;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        touch_en      = 1'b0;
        inst_en       = 1'b0;
        dirty_en      = 1'b0;
        we_word       = 1'b0;
        we_byte       = 1'b0;
        do_rsp        = 1'b0;
        capture       = 1'b0;
        beat_inc      = 1'b0;
        beat_clr      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (|hit) begin
                        touch_en = 1'b1;
                        do_rsp   = 1'b1;
                        we_byte  = req_write;
                        dirty_en = req_write;
                    end else begin
                        capture = 1'b1;
                        state_d = vic_dirty ? ST_WBACK : ST_FREQ;
                    end
                end
            end
            ST_WBACK: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {vline_q, beat_q, 2'b00};
                if (mem_req_ready) begin
                    if (&beat_q) begin
                        beat_clr = 1'b1;
                        state_d  = ST_FREQ;
                    end else begin
                        beat_inc = 1'b1;
                    end
                end
            end
            ST_FREQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = {pend_addr_q[CHUNK_W-1:BYTE_W], beat_q, 2'b00};
                if (mem_req_ready) state_d = ST_FWAIT;
            end
            ST_FWAIT: begin
                if (mem_rsp_valid) begin
                    we_word = 1'b1;
                    if (&beat_q) begin
                        inst_en  = 1'b1;
                        beat_clr = 1'b1;
                        state_d  = ST_DONE;
                    end else begin
                        beat_inc = 1'b1;
                        state_d  = ST_FREQ;
                    end
                end
            end
            ST_DONE: begin
                touch_en = 1'b1;
                do_rsp   = 1'b1;
                we_byte  = pend_write_q;
                dirty_en = pend_write_q;
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_addr_q  <= '0;
            pend_write_q <= 1'b0;
            pend_wtag_q  <= '0;
            way_q        <= 1'b0;
            vline_q      <= '0;
            beat_q       <= '0;
            rsp_valid_q  <= 1'b0;
            rsp_tag_q    <= '0;
        end else begin
            if (capture) begin
                pend_addr_q  <= req_addr;
                pend_write_q <= req_write;
                pend_wtag_q  <= req_wtag;
                way_q        <= vic_way;
                vline_q      <= vic_line;
                beat_q       <= '0;
            end else if (beat_clr) begin
                beat_q <= '0;
            end else if (beat_inc) begin
                beat_q <= beat_q + 1'b1;
            end
            rsp_valid_q <= do_rsp;
            if (do_rsp) rsp_tag_q <= op_write ? wr_tag : st_rd_tag;
        end
    end

    // R10: a stalled memory request stays put
    p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata));

    // R5: a miss raises busy on the next cycle
    p_miss_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy && !(|hit) |=> busy);

    // R5: no response while a miss is in service
    p_busy_norsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rsp_valid);

    // R5: the end of a miss carries the held access's response
    p_done_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rsp_valid);

    // R2: a hit answers in the following cycle without stalling
    p_hit_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy && (|hit) |=> rsp_valid && !busy);
endmodule

// File: rtl/taint_tag_cache.sv
module taint_tag_cache #(
    parameter int CHUNK_W     = 29,
    parameter int CACHE_BYTES = 512,
    parameter int LINE_BYTES  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [CHUNK_W-1:0] req_addr,
    input  logic [7:0]         req_wtag,
    output logic               busy,
    output logic               rsp_valid,
    output logic [7:0]         rsp_rtag,
    output logic               mem_req_valid,
    output logic               mem_req_write,
    output logic [CHUNK_W-1:0] mem_req_addr,
    output logic [31:0]        mem_req_wdata,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  logic [31:0]        mem_rsp_rdata
);
    localparam int SETS   = CACHE_BYTES / (2 * LINE_BYTES);
    localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int BYTE_W = $clog2(LINE_BYTES);
    localparam int BEAT_W = BYTE_W - 2;
    localparam int LINE_W = CHUNK_W - BYTE_W;

    logic [SET_W-1:0]  lk_set;
    logic [LINE_W-1:0] lk_line;
    logic [1:0]        hit;
    logic              hit_way, vic_way, vic_dirty;
    logic [LINE_W-1:0] vic_line;
    logic              op_way, touch_en, inst_en, dirty_en;
    logic [BYTE_W-1:0] st_byte;
    logic [BEAT_W-1:0] st_beat;
    logic              we_word, we_byte;
    logic [7:0]        wr_tag, st_rd_tag;
    logic [31:0]       st_rd_word;

    ttc_ctrl #(
        .CHUNK_W(CHUNK_W), .SETS(SETS), .SET_W(SET_W),
        .BYTE_W(BYTE_W), .BEAT_W(BEAT_W), .LINE_W(LINE_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wtag(req_wtag),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_rtag(rsp_rtag),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .lk_set(lk_set), .lk_line(lk_line), .hit(hit), .hit_way(hit_way),
        .vic_way(vic_way), .vic_dirty(vic_dirty), .vic_line(vic_line),
        .op_way(op_way), .touch_en(touch_en), .inst_en(inst_en), .dirty_en(dirty_en),
        .st_byte(st_byte), .st_beat(st_beat), .we_word(we_word), .we_byte(we_byte),
        .wr_tag(wr_tag), .st_rd_tag(st_rd_tag), .st_rd_word(st_rd_word)
    );

    ttc_dir #(.SETS(SETS), .SET_W(SET_W), .LINE_W(LINE_W)) u_dir (
        .clk(clk), .rst_n(rst_n), .lk_set(lk_set), .lk_line(lk_line), .op_way(op_way),
        .touch_en(touch_en), .inst_en(inst_en), .dirty_en(dirty_en),
        .hit(hit), .hit_way(hit_way), .vic_way(vic_way), .vic_dirty(vic_dirty),
        .vic_line(vic_line)
    );

    ttc_store #(
        .SETS(SETS), .SET_W(SET_W), .LINE_BYTES(LINE_BYTES),
        .BYTE_W(BYTE_W), .BEAT_W(BEAT_W)
    ) u_store (
        .clk(clk), .set_idx(lk_set), .way(op_way), .byte_idx(st_byte), .beat_idx(st_beat),
        .we_word(we_word), .wr_word(mem_rsp_rdata), .we_byte(we_byte), .wr_tag(wr_tag),
        .rd_tag(st_rd_tag), .rd_word(st_rd_word)
    );
endmodule

// File: tb/taint_tag_cache_tb.sv
module taint_tag_cache_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 9;
    localparam int NB = 1 << CW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [CW-1:0] req_addr = '0;
    logic [7:0]    req_wtag = '0;
    logic          busy, rsp_valid;
    logic [7:0]    rsp_rtag;
    logic          mem_req_valid, mem_req_write;
    logic [CW-1:0] mem_req_addr;
    logic [31:0]   mem_req_wdata;
    logic          mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [31:0]   mem_rsp_rdata = '0;

    taint_tag_cache #(.CHUNK_W(CW), .CACHE_BYTES(64), .LINE_BYTES(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wtag(req_wtag), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_rtag(rsp_rtag), .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    int n_cmp = 0, n_bad = 0;
    int n_rd = 0, n_wr = 0, seq_err = 0, ord_err = 0, hold_err = 0;
    logic [7:0] bmem [NB];
    logic [7:0] ref_t [NB];

    // shared-bus model: acts at the falling edge for the coming rising edge
    logic          rd_pend, saw_rd, prev_stall, prev_wr;
    int            rd_wait;
    logic [CW-1:0] rd_addr, last_rd, last_wr, prev_addr;
    logic [31:0]   prev_data;
    logic [15:0]   mlfsr;

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) bmem[i] = 8'(i * 7 + 3);
            rd_pend = 1'b0; saw_rd = 1'b0; prev_stall = 1'b0; prev_wr = 1'b0;
            rd_wait = 0; rd_addr = '0; last_rd = '0; last_wr = '0; prev_addr = '0;
            prev_data = '0; mlfsr = 16'hACE1;
            mem_rsp_valid = 1'b0; mem_req_ready = 1'b0;
        end else begin
            if (prev_stall && !(mem_req_valid && mem_req_addr == prev_addr &&
                                mem_req_write == prev_wr && (!prev_wr || mem_req_wdata == prev_data)))
                hold_err++;
            mem_rsp_valid = 1'b0;
            if (rd_pend) begin
                if (rd_wait == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = {bmem[int'(rd_addr)+3], bmem[int'(rd_addr)+2],
                                     bmem[int'(rd_addr)+1], bmem[int'(rd_addr)]};
                    rd_pend = 1'b0;
                end else begin
                    rd_wait--;
                end
            end
            mlfsr = {mlfsr[14:0], mlfsr[15] ^ mlfsr[13] ^ mlfsr[12] ^ mlfsr[10]};
            mem_req_ready = mlfsr[0] | mlfsr[1];
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    for (int k = 0; k < 4; k++) bmem[int'(mem_req_addr)+k] = mem_req_wdata[8*k +: 8];
                    n_wr++;
                    if (saw_rd) ord_err++;
                    if (mem_req_addr[3:2] != 2'd0 && mem_req_addr != last_wr + CW'(4)) seq_err++;
                    last_wr = mem_req_addr;
                end else begin
                    if (rd_pend) seq_err++;
                    if (mem_req_addr[3:2] != 2'd0 && mem_req_addr != last_rd + CW'(4)) seq_err++;
                    rd_pend = 1'b1; rd_wait = int'(mlfsr[3:2]); rd_addr = mem_req_addr;
                    last_rd = mem_req_addr; n_rd++; saw_rd = 1'b1;
                end
            end
            prev_stall = mem_req_valid && !mem_req_ready;
            prev_addr = mem_req_addr; prev_wr = mem_req_write; prev_data = mem_req_wdata;
            if (!busy) saw_rd = 1'b0;
        end
    end

    task automatic check(input string lbl, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", lbl, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic acc(input logic wr, input logic [CW-1:0] a, input logic [7:0] t,
                       output logic [7:0] got, output int lat);
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wtag = t;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        got = rsp_rtag;
        if (!rsp_valid) check("R5 response missing", 0, 1);
        if (wr) ref_t[a] = t;
    endtask

    task automatic step(input string lbl, input logic wr, input logic [CW-1:0] a,
                        input logic [7:0] t, input int e_rd, input int e_wr);
        int r0 = n_rd;
        int w0 = n_wr;
        logic [7:0] expv = wr ? t : ref_t[a];
        logic [7:0] got;
        int lat;
        acc(wr, a, t, got, lat);
        check({lbl, " value"}, int'(got), int'(expv));
        check({lbl, " one-cycle hit"}, int'(lat == 1), int'(e_rd == 0));
        check({lbl, " fill beats"}, n_rd - r0, e_rd);
        check({lbl, " writeback beats"}, n_wr - w0, e_wr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        logic [7:0]  got;
        logic [15:0] r;
        logic [CW-1:0] a;
        int lat;
        for (int i = 0; i < NB; i++) ref_t[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 rsp_valid after reset", int'(rsp_valid), 0);
        check("R1 mem_req_valid after reset", int'(mem_req_valid), 0);

        // set 0 holds lines 0x00, 0x02, 0x04 (tag byte bit 4 clear)
        step("R1 R6 R4 cold miss", 1'b0, 9'h005, 8'h00, 4, 0);
        step("R2 read hit", 1'b0, 9'h00A, 8'h00, 0, 0);
        step("R3 write hit", 1'b1, 9'h003, 8'h5A, 0, 0);
        step("R3 readback", 1'b0, 9'h003, 8'h00, 0, 0);
        step("R8 fill into empty way", 1'b0, 9'h021, 8'h00, 4, 0);
        step("R2 hit refreshes lru", 1'b0, 9'h001, 8'h00, 0, 0);
        step("R9 R8 clean lru victim", 1'b0, 9'h041, 8'h00, 4, 0);
        step("R7 R8 dirty lru victim", 1'b0, 9'h022, 8'h00, 4, 4);
        check("R4 written-back byte lane", int'(bmem[3]), 'h5A);
        check("R4 neighbour byte kept", int'(bmem[4]), (4 * 7 + 3));
        step("R7 refill of written-back data", 1'b0, 9'h003, 8'h00, 4, 0);

        // R5: a write presented during a miss must be ignored
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 9'h130;
        @(negedge clk);
        check("R5 busy after miss", int'(busy), 1);
        req_write = 1'b1; req_addr = 9'h003; req_wtag = 8'hEE;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        check("R5 held miss response", int'(rsp_rtag), int'(ref_t[9'h130]));
        step("R5 write during busy ignored", 1'b0, 9'h003, 8'h00, 0, 0);
        step("R11 other set leaves set 0", 1'b0, 9'h022, 8'h00, 0, 0);

        // full sweep of tag space
        for (int i = 0; i < NB; i++) begin
            acc(1'b1, CW'(i), 8'(i * 13 + 1), got, lat);
            check("R3 sweep write echo", int'(got), (i * 13 + 1) % 256);
        end
        for (int i = 0; i < NB; i++) begin
            acc(1'b0, CW'(i), 8'h00, got, lat);
            check("R4 sweep read", int'(got), int'(ref_t[i]));
        end

        // random stream, half of it thrashing set 0
        r = 16'h1D2B;
        for (int n = 0; n < 2000; n++) begin
            r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
            a = r[CW-1:0];
            if (r[15]) a[4] = 1'b0;
            if (r[11]) begin
                acc(1'b1, a, r[7:0] ^ r[15:8], got, lat);
                check("R3 random write echo", int'(got), int'(ref_t[a]));
            end else begin
                acc(1'b0, a, 8'h00, got, lat);
                check("R8 R11 random read", int'(got), int'(ref_t[a]));
            end
        end

        check("R6 beat order and single outstanding read", seq_err, 0);
        check("R7 writeback precedes fill", ord_err, 0);
        check("R10 stalled request held", hold_err, 0);
        report();
        $finish;
    end
endmodule